// File: doc/BRIEF.md
# Double-Buffered Host-to-Serial Byte Converter

The block accepts bytes from a microprocessor-style host bus and sends them out one bit per serial clock. The host write cycle is asynchronous to the serial clock: a low-going write strobe, qualified by two chip selects and an inactive read strobe, presents a byte. The converter keeps the byte in a staging input register. When the write ends, it commits the byte to a holding register and then moves it into a shift register. A bit-valid flag marks the serial clock cycles that carry data.

There are two buffer levels, so the `ready` handshake depends on how full they are. When the shifter is empty, the held byte passes into it at once and busy is short. When a byte arrives while the shifter is still sending, the byte waits in the holding register and `ready` stays low until the shifter takes it. A host can watch `ready` directly. It can also poll the busy flag with a status read, which returns the flag on the top bit of the status bus.

Top module: `byte_serializer`

## Requirements
- R1: A write cycle is recognised only while `sel_lo_n`=0, `sel_hi`=1, `rstrb_n`=1 and `wstrb_n`=0. A strobe pulse under any other combination of the three qualifiers leaves `ready` high and produces no serial bits.
- R2: The byte sent is the value on `host_d` at the last serial clock edge inside the active write cycle. Changing `host_d` after `wstrb_n` rises has no effect on that byte.
- R3: The serial clock edge that follows `wstrb_n` rising is edge one. `ready` is still high after edges one and two and is low after edge three.
- R4: When a byte is written while both buffers are empty, `ready` stays low for exactly 2 serial clock cycles. The first serial bit is valid in the cycle after `ready` falls.
- R5: Bit 0 goes out first and bit 7 last, one bit per cycle, with `ser_vld` high for 8 cycles per byte. When `ser_vld` is low, `ser_d` is 1.
- R6: A byte that waits in the holding register enters the shifter on the edge that ends the previous byte's last bit, so the stream has no gap. `ready` returns high one cycle later. Under a host that obeys `ready`, a busy period lasts 2 to 9 cycles.
- R7: A status read is active while `sel_lo_n`=0, `sel_hi`=1, `rstrb_n`=0 and `wstrb_n`=1. During a status read, `stat_q` bit 7 is 1 when busy and 0 when ready, and bits 6..0 are 0. At all other times `stat_q` is 0.
- R8: While `rst_n` is low at a clock edge, both buffers are emptied, `ready` goes high, `ser_vld` goes low and `ser_d` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| wstrb_n | input | 1 | Host write strobe, active low, asynchronous |
| rstrb_n | input | 1 | Host read strobe, active low |
| host_d | input | 8 | Host write data |
| stat_q | output | 8 | Status read data, busy flag on bit 7 |
| ser_d | output | 1 | Serial data |
| ser_vld | output | 1 | Serial bit valid |
| ready | output | 1 | High when a new byte may be written |

## Verification
A holding register that is wrongly marked full or empty shows up within one cycle of the transfer point. A stale full flag stretches `ready` low beyond its 2-cycle or 9-cycle bound. A missed hand-off leaves a gap between back-to-back bytes. A wrong shift count or bit order shows on `ser_vld` run lengths and on the reassembled bytes as soon as the byte finishes. A synchronizer or edge detector with the wrong depth moves the fall of `ready` off the third edge after the strobe ends.

// File: rtl/bs_pkg.sv
// Shared constants for the byte serializer.
// Assumes: a byte fits the status bus, with the busy flag in the top bit.
package bs_pkg;
    parameter int unsigned BS_BYTE_W   = 8;
    parameter int unsigned BS_SYNC_N   = 2;
    parameter int unsigned BS_BUSY_MAX = 9;

    // Status word for a read cycle: busy flag in the top bit, rest zero.
    function automatic logic [BS_BYTE_W-1:0] bs_status(input logic busy);
        logic [BS_BYTE_W-1:0] w;
        w = '0;
        w[BS_BYTE_W-1] = busy;
        return w;
    endfunction
endpackage

// File: rtl/bs_strobe.sv
// Write strobe decoder and synchronizer.
// Decodes the host write cycle and brings it into the serial clock domain
// through SYNC_N flops, then flags the trailing edge of the cycle.
// Assumes: selects are stable while the write strobe is low.
module bs_strobe #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lo_n,
    input  logic sel_hi,
    input  logic wstrb_n,
    input  logic rstrb_n,
    output logic wr_raw,
    output logic wr_done
);
    localparam int unsigned CHAIN_N = SYNC_N + 1;

    logic [CHAIN_N-1:0] chain;

    // Decode the asynchronous write cycle.
    assign wr_raw = !sel_lo_n && sel_hi && rstrb_n && !wstrb_n;

    // Synchronizer flops plus one delay stage for edge detection.
    generate
        for (genvar i = 0; i < CHAIN_N; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= wr_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Trailing edge of the synchronized write cycle.
    assign wr_done = chain[CHAIN_N-1] && !chain[CHAIN_N-2];
endmodule

// File: rtl/bs_hold.sv
// Input buffer stage: staging register, holding register and ready flag.
// Staging follows host data during the write cycle. The holding register
// takes the staged byte when the cycle ends and is freed when the shifter
// takes it. Ready falls on commit and rises one cycle after the holding
// register is freed.
// Assumes: host data is stable while the write cycle is active.
module bs_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_raw,
    input  logic              wr_done,
    input  logic              take,
    input  logic [BYTE_W-1:0] host_d,
    output logic [BYTE_W-1:0] hold_q,
    output logic              hold_full,
    output logic              ready
);
    logic [BYTE_W-1:0] stage_q;

    // Track host data during the active write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (wr_raw) stage_q <= host_d;
    end

    // Commit on end of write, free on hand-off to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (wr_done) begin
            hold_q    <= stage_q;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // Ready drops on commit and follows the holding state one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n)       ready <= 1'b1;
        else if (wr_done) ready <= 1'b0;
        else              ready <= !hold_full;
    end
endmodule

// File: rtl/bs_shift.sv
// Second-level shift register, least significant bit first.
// Takes the held byte when empty or on its last bit, so the stream stays
// continuous. The line idles high.
// Assumes: hold_q is valid whenever hold_full is set.
module bs_shift #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic [BYTE_W-1:0] hold_q,
    output logic              take,
    output logic              ser_d,
    output logic              ser_vld
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Hand-off when idle or during the final bit.
    assign take = hold_full && (cnt_q <= CNT_ONE);

    // Load or shift the data and bits-remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= hold_q;
            cnt_q <= CNT_FULL;
        end else if (cnt_q != '0) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Serial line: current bit when valid, idle high otherwise.
    assign ser_vld = (cnt_q != '0);
    assign ser_d   = ser_vld ? sh_q[0] : 1'b1;
endmodule

// File: rtl/byte_serializer.sv
// Double-buffered host-to-serial byte converter, top level.
// Connects strobe decode, input buffering and shifting, and drives the
// status read bus from the ready flag.
// Assumes: clk is the serial clock and the host obeys ready.
module byte_serializer
    import bs_pkg::*;
#(
    parameter int unsigned BYTE_W = BS_BYTE_W,
    parameter int unsigned SYNC_N = BS_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wstrb_n,
    input  logic              rstrb_n,
    input  logic [BYTE_W-1:0] host_d,
    output logic [BYTE_W-1:0] stat_q,
    output logic              ser_d,
    output logic              ser_vld,
    output logic              ready
);
    logic              wr_raw;
    logic              wr_done;
    logic              take;
    logic              hold_full;
    logic [BYTE_W-1:0] hold_q;
    logic              rd_act;

    bs_strobe #(.SYNC_N(SYNC_N)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_lo_n(sel_lo_n),
        .sel_hi  (sel_hi),
        .wstrb_n (wstrb_n),
        .rstrb_n (rstrb_n),
        .wr_raw  (wr_raw),
        .wr_done (wr_done)
    );

    bs_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_raw   (wr_raw),
        .wr_done  (wr_done),
        .take     (take),
        .host_d   (host_d),
        .hold_q   (hold_q),
        .hold_full(hold_full),
        .ready    (ready)
    );

    bs_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_full(hold_full),
        .hold_q   (hold_q),
        .take     (take),
        .ser_d    (ser_d),
        .ser_vld  (ser_vld)
    );

    // Status read decode and busy flag return.
    assign rd_act = !sel_lo_n && sel_hi && !rstrb_n && wstrb_n;
    always_comb begin
        stat_q = '0;
        if (rd_act) begin
            stat_q = '0;
            stat_q[BYTE_W-1] = !ready;
        end
    end
endmodule

// File: rtl/bs_check.sv
// Assertion checker for byte_serializer, attached by bind.
// Watches ports only: busy length bounds, serial run framing, idle line
// level and status read content.
module bs_check #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_lo_n,
    input logic              sel_hi,
    input logic              wstrb_n,
    input logic              rstrb_n,
    input logic [BYTE_W-1:0] stat_q,
    input logic              ser_d,
    input logic              ser_vld,
    input logic              ready
);
    localparam int unsigned RUN_W = $clog2(BYTE_W);

    logic [4:0]       low_cnt;
    logic [RUN_W-1:0] run_cnt;

    // Count consecutive busy cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt <= '0;
        else if (ready)            low_cnt <= '0;
        else if (low_cnt != 5'd31) low_cnt <= low_cnt + 5'd1;
    end

    // Count valid serial cycles modulo the byte width.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_cnt <= '0;
        else if (ser_vld) run_cnt <= run_cnt + RUN_W'(1);
        else              run_cnt <= '0;
    end

    p_busy_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= 5'd9);

    p_busy_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> low_cnt >= 5'd2);

    p_run_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_vld) |-> run_cnt == '0);

    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_vld |-> ser_d);

    p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && !rstrb_n && wstrb_n) |->
            (stat_q[BYTE_W-1] == !ready) && (stat_q[BYTE_W-2:0] == '0));

    p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_lo_n && sel_hi && !rstrb_n && wstrb_n) |-> stat_q == '0);
endmodule

bind byte_serializer bs_check #(.BYTE_W(BYTE_W)) u_bs_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_lo_n(sel_lo_n),
    .sel_hi  (sel_hi),
    .wstrb_n (wstrb_n),
    .rstrb_n (rstrb_n),
    .stat_q  (stat_q),
    .ser_d   (ser_d),
    .ser_vld (ser_vld),
    .ready   (ready)
);

// File: tb/test_byte_serializer.sv
module test_byte_serializer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_lo_n = 1'b1;
    logic       sel_hi = 1'b0;
    logic       wstrb_n = 1'b1;
    logic       rstrb_n = 1'b1;
    logic [7:0] host_d = 8'h00;
    logic [7:0] stat_q;
    logic       ser_d;
    logic       ser_vld;
    logic       ready;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Monitor state.
    int cyc = 0;
    int nfalls = 0;
    int fall_cyc = 0;
    int rise_cyc = 0;
    int last_busy = 0;
    int vld_start = 0;
    int run_len = 0;
    int last_run = 0;
    int nbits = 0;
    bit prev_rdy = 1'b1;
    bit prev_vld = 1'b0;
    bit got [0:1023];
    logic [7:0] exp_b [0:127];
    int nexp = 0;

    byte_serializer i_byte_serializer (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .wstrb_n(wstrb_n), .rstrb_n(rstrb_n), .host_d(host_d),
        .stat_q(stat_q), .ser_d(ser_d), .ser_vld(ser_vld), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (prev_rdy && !ready) begin
                nfalls = nfalls + 1;
                fall_cyc = cyc;
            end
            if (!prev_rdy && ready) begin
                rise_cyc = cyc;
                last_busy = cyc - fall_cyc;
            end
            if (ser_vld) begin
                if (nbits < 1024) got[nbits] = ser_d;
                nbits = nbits + 1;
                if (!prev_vld) vld_start = cyc;
                run_len = run_len + 1;
            end else if (prev_vld) begin
                last_run = run_len;
                run_len = 0;
            end
            prev_rdy = ready;
            prev_vld = ser_vld;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_wr(input logic [7:0] d, input logic lo_n, input logic hi, input logic rd_n);
        host_d = d; sel_lo_n = lo_n; sel_hi = hi; rstrb_n = rd_n; wstrb_n = 1'b0;
    endtask

    task automatic end_wr();
        wstrb_n = 1'b1; host_d = ~host_d;
        sel_lo_n = 1'b1; sel_hi = 1'b0; rstrb_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state seen before release
        chk(ready == 1'b1, "R8 ready", ready, 1);
        chk(ser_vld == 1'b0, "R8 ser_vld", ser_vld, 0);
        chk(ser_d == 1'b1, "R8 ser_d", ser_d, 1);
        chk(stat_q == 8'h00, "R8 stat_q", stat_q, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R3 / R4: sweep every qualifier combination, each with two bytes
        for (int rep = 0; rep < 2; rep++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] d;
                int nf0;
                int nb0;
                bit valid;
                bit r1;
                bit r2;
                bit r3;
                d = (rep == 0) ? 8'(c * 37 + 5) : ((c == 6) ? 8'hFF : 8'(c * 91));
                if (rep == 1 && c == 5) d = 8'h00;
                valid = (c == 6);
                nf0 = nfalls; nb0 = nbits;
                @(negedge clk);
                start_wr(d, c[0], c[1], c[2]);
                repeat (2) @(negedge clk);
                end_wr();
                @(negedge clk); r1 = ready;
                @(negedge clk); r2 = ready;
                @(negedge clk); r3 = ready;
                repeat (14) @(negedge clk);
                #1;
                if (valid) begin
                    exp_b[nexp] = d; nexp++;
                    chk(r1 && r2 && !r3, "R3 ready fall edge", {r1, r2, r3}, 3'b110);
                    chk(nfalls == nf0 + 1, "R1 accepted write", nfalls - nf0, 1);
                    chk(last_busy == 2, "R4 empty busy", last_busy, 2);
                    chk(vld_start == fall_cyc + 1, "R4 first bit", vld_start - fall_cyc, 1);
                    chk(last_run == 8, "R5 run length", last_run, 8);
                end else begin
                    chk(nfalls == nf0, "R1 ignored ready", nfalls - nf0, 0);
                    chk(nbits == nb0, "R1 ignored serial", nbits - nb0, 0);
                end
            end
        end

        // R6: back-to-back pairs with the second strobe started during busy
        for (int k = 0; k < 3; k++) begin
            logic [7:0] a;
            logic [7:0] b;
            int fa;
            int guard;
            a = 8'(8'h5A ^ (k * 8'h33));
            b = 8'(8'hC3 + k * 8'h29);
            @(negedge clk);
            start_wr(a, 1'b0, 1'b1, 1'b1);
            repeat (2) @(negedge clk);
            end_wr();
            guard = 0;
            do begin @(negedge clk); guard++; end while (ready && guard < 10);
            start_wr(b, 1'b0, 1'b1, 1'b1);
            #1 fa = fall_cyc;
            guard = 0;
            do begin @(negedge clk); guard++; end while (!ready && guard < 12);
            @(negedge clk);
            end_wr();
            exp_b[nexp] = a; nexp++;
            exp_b[nexp] = b; nexp++;
            repeat (24) @(negedge clk);
            #1;
            chk(last_busy == 4, "R6 queued busy", last_busy, 4);
            chk(rise_cyc - fa == 10, "R6 ready after hand-off", rise_cyc - fa, 10);
            chk(last_run == 16, "R6 gapless stream", last_run, 16);
        end

        // R7: status reads while busy, while idle, and while not selected
        @(negedge clk);
        start_wr(8'h96, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        end_wr();
        exp_b[nexp] = 8'h96; nexp++;
        do @(negedge clk); while (ready);
        sel_lo_n = 1'b0; sel_hi = 1'b0; rstrb_n = 1'b0;
        #1 chk(stat_q == 8'h00, "R7 read unselected", stat_q, 0);
        sel_hi = 1'b1;
        #1 chk(stat_q == 8'h80, "R7 read busy", stat_q, 8'h80);
        @(negedge clk);
        sel_lo_n = 1'b1; sel_hi = 1'b0; rstrb_n = 1'b1;
        repeat (14) @(negedge clk);
        sel_lo_n = 1'b0; sel_hi = 1'b1; rstrb_n = 1'b0;
        #1 chk(stat_q == 8'h00, "R7 read ready", stat_q, 0);
        @(negedge clk);
        sel_lo_n = 1'b1; sel_hi = 1'b0; rstrb_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;

        // R2 / R5: reassemble the serial stream, bit 0 first
        chk(nbits == nexp * 8, "R5 bit count", nbits, nexp * 8);
        for (int i = 0; i < nexp; i++) begin
            logic [7:0] g;
            for (int j = 0; j < 8; j++) g[j] = got[i * 8 + j];
            chk(g == exp_b[i], "R2 R5 byte value", g, exp_b[i]);
        end
        chk(ser_d == 1'b1 && !ser_vld, "R5 idle line", ser_d, 1);

        // R8: reset in mid-byte empties everything
        @(negedge clk);
        start_wr(8'h3C, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        end_wr();
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready && !ser_vld && ser_d, "R8 reset mid-byte", {ready, ser_vld, ser_d}, 3'b101);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule